// File: doc/BRIEF.md
# Multi-Width Shift and Rotate Unit

This unit is the shift/rotate slice of an execution stage. Each cycle it may accept one operand together with an operation code, an operand width (byte, word or long), a shift count of one or two places, and the current carry flag. One clock edge later it presents the result, zero-extended to the datapath width, and a fresh set of N, Z, V and C condition flags.

Four operations are supported. There are logical left and right shifts, by one or two places. There is a plain rotate right, and a rotate right that passes through the carry flag. A two-place shift is built as two chained one-place steps, so the carry it reports is the second bit shifted out. The rotates always move one place.

Register-file access and instruction decode are handled outside the unit. The surrounding pipeline drives an accepted operation with `valid_i` and captures the registered outputs on the next cycle.

Top module: `shift_rot_unit`

## Requirements
- R1: While rst_ni is low, valid_o, result_o and all four flag outputs are 0.
- R2: valid_o equals valid_i from the previous clock edge. The result and flag outputs update only on an edge where valid_i is 1, and otherwise hold their values.
- R3: op_i = 0 is a logical left shift that fills with zeros. With amount_i = 1 it moves two places, equal to two one-place steps. C is the last bit shifted out of the selected width's top bit.
- R4: op_i = 1 is a logical right shift that fills with zeros. With amount_i = 1 it moves two places. C is the last bit shifted out of bit 0.
- R5: op_i = 2 is a one-place rotate right. Old bit 0 enters the top bit of the selected width, and C takes old bit 0. amount_i and carry_i have no effect.
- R6: op_i = 3 is a one-place rotate right through carry. carry_i enters the top bit of the selected width, and C takes old bit 0. amount_i has no effect. carry_i has no effect on ops 0 to 2.
- R7: For every operation, N is the top bit of the result at the selected width, Z is 1 exactly when the result is zero, and V is 0.
- R8: width_i selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. Operand bits above the selected width are ignored, and result bits above it are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation accepted this cycle |
| operand_i | input | 32 | Source operand |
| width_i | input | 2 | Operand width select |
| op_i | input | 2 | Operation select |
| amount_i | input | 1 | 0: one place, 1: two places (shifts only) |
| carry_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Zero-extended result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag (always cleared) |
| flag_c_o | output | 1 | Carry flag |

## Verification
Random operands with garbage placed above the selected width test whether the high bits are masked. Operands with chosen top and bottom bits separate the single-step carry from the second shifted-out bit, and separate rotate from rotate-through-carry. Operands that shift to zero exercise the Z flag. Cycles with valid low and a changed operand confirm that the registered outputs hold.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [1:0] {
    OP_SHL   = 2'd0,
    OP_SHR   = 2'd1,
    OP_ROTR  = 2'd2,
    OP_ROTXR = 2'd3
  } sru_op_e;

  typedef enum logic [1:0] {
    WD_BYTE = 2'd0,
    WD_WORD = 2'd1,
    WD_LONG = 2'd2,
    WD_ALT  = 2'd3
  } sru_width_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } sru_flags_t;

  localparam int NUM_LANES = 3;
endpackage

// File: rtl/sru_step.sv
module sru_step #(
  parameter int W = 8
) (
  input  sru_pkg::sru_op_e op_i,
  input  logic [W-1:0]     data_i,
  input  logic             cin_i,
  output logic [W-1:0]     data_o,
  output logic             cout_o
);
  import sru_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_SHL: begin
        data_o = {data_i[W-2:0], 1'b0};
        cout_o = data_i[W-1];
      end
      OP_SHR: begin
        data_o = {1'b0, data_i[W-1:1]};
        cout_o = data_i[0];
      end
      OP_ROTR: begin
        data_o = {data_i[0], data_i[W-1:1]};
        cout_o = data_i[0];
      end
      default: begin
        data_o = {cin_i, data_i[W-1:1]};
        cout_o = data_i[0];
      end
    endcase
  end
endmodule

// File: rtl/sru_lane.sv
module sru_lane #(
  parameter int W = 8
) (
  input  sru_pkg::sru_op_e   op_i,
  input  logic               two_i,
  input  logic               cin_i,
  input  logic [W-1:0]       data_i,
  output logic [W-1:0]       res_o,
  output sru_pkg::sru_flags_t flags_o
);
  import sru_pkg::*;

  logic [W-1:0] s1_data, s2_data;
  logic         s1_c, s2_c;
  logic         take_second;

  sru_step #(.W(W)) u_step1 (
    .op_i(op_i), .data_i(data_i), .cin_i(cin_i),
    .data_o(s1_data), .cout_o(s1_c)
  );

  // second step chains the first step's carry
  sru_step #(.W(W)) u_step2 (
    .op_i(op_i), .data_i(s1_data), .cin_i(s1_c),
    .data_o(s2_data), .cout_o(s2_c)
  );

  // rotates are single-step only
  assign take_second = two_i && (op_i == OP_SHL || op_i == OP_SHR);

  always_comb begin
    res_o     = take_second ? s2_data : s1_data;
    flags_o.c = take_second ? s2_c : s1_c;
    flags_o.n = res_o[W-1];
    flags_o.z = (res_o == '0);
    flags_o.v = 1'b0;
  end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [1:0]        width_i,
  input  logic [1:0]        op_i,
  input  logic              amount_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o
);
  import sru_pkg::*;

  sru_op_e            op;
  logic [DATA_W-1:0]  lane_res [NUM_LANES];
  sru_flags_t         lane_flg [NUM_LANES];
  logic [1:0]         sel;
  logic [DATA_W-1:0]  res_q;
  sru_flags_t         flg_q;
  logic               valid_q;

  assign op = sru_op_e'(op_i);

  // lane g handles DATA_W >> (2-g) bits: quarter, half, full
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = DATA_W >> (NUM_LANES - 1 - g);
    logic [LW-1:0] r;
    sru_lane #(.W(LW)) u_lane (
      .op_i(op), .two_i(amount_i), .cin_i(carry_i),
      .data_i(operand_i[LW-1:0]),
      .res_o(r), .flags_o(lane_flg[g])
    );
    assign lane_res[g] = DATA_W'(r);
  end

  always_comb begin
    unique case (sru_width_e'(width_i))
      WD_BYTE: sel = 2'd0;
      WD_WORD: sel = 2'd1;
      default: sel = 2'd2;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flg_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q <= lane_res[sel];
        flg_q <= lane_flg[sel];
      end
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign flag_n_o = flg_q.n;
  assign flag_z_o = flg_q.z;
  assign flag_v_o = flg_q.v;
  assign flag_c_o = flg_q.c;
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [1:0]        width_i,
  input logic [1:0]        op_i,
  input logic              amount_i,
  input logic              carry_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic              flag_v_o,
  input logic              flag_c_o
);
  function automatic int top_idx(input logic [1:0] w);
    return (w == 2'd0) ? DATA_W/4 - 1 : (w == 2'd1) ? DATA_W/2 - 1 : DATA_W - 1;
  endfunction

  function automatic logic [DATA_W-1:0] hi_mask(input logic [1:0] w);
    logic [DATA_W-1:0] m;
    m = '1;
    m = m << (top_idx(w) + 1);
    if (top_idx(w) == DATA_W - 1) m = '0;
    return m;
  endfunction

  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(flag_c_o));
  a_r8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (result_o & hi_mask($past(width_i))) == '0);
  a_r7_v_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !flag_v_o);
  a_r7_z_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> flag_z_o == (result_o == '0));
  a_r7_n_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flag_n_o == result_o[top_idx($past(width_i))]);
  a_r5_rotr_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd2) |=>
      flag_c_o == $past(operand_i[0]) &&
      result_o[top_idx($past(width_i))] == $past(operand_i[0]));
  a_r6_rotxr_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd3) |=>
      flag_c_o == $past(operand_i[0]) &&
      result_o[top_idx($past(width_i))] == $past(carry_i));
  always_comb begin
    if (!rst_ni) a_r1_reset: assert (!valid_o || $isunknown(valid_o));
  end
endmodule

bind shift_rot_unit sru_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_shift_rot_unit.sv
module sim_shift_rot_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [1:0]  width_i = '0;
  logic [1:0]  op_i = '0;
  logic        amount_i = 1'b0;
  logic        carry_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  shift_rot_unit u0 (.*);

  // returns {n, z, v, c, result}
  function automatic logic [35:0] model(input logic [1:0] op, input logic [1:0] wd,
                                         input logic two, input logic cin,
                                         input logic [31:0] a);
    int w;
    logic [31:0] mask, d;
    logic c, nb;
    int steps;
    w = (wd == 2'd0) ? 8 : (wd == 2'd1) ? 16 : 32;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    d = a & mask;
    c = cin;
    steps = (op < 2'd2 && two) ? 2 : 1;
    for (int k = 0; k < steps; k++) begin
      case (op)
        2'd0: begin c = d[w-1]; d = (d << 1) & mask; end
        2'd1: begin c = d[0]; d = d >> 1; end
        2'd2: begin c = d[0]; d = (d >> 1) | ({31'b0, c} << (w - 1)); end
        default: begin nb = c; c = d[0]; d = (d >> 1) | ({31'b0, nb} << (w - 1)); end
      endcase
    end
    return {d[w-1], d == 32'd0, 1'b0, c, d};
  endfunction

  function automatic string tag_of(input logic [1:0] op);
    case (op)
      2'd0: return "R3/R7/R8";
      2'd1: return "R4/R7/R8";
      2'd2: return "R5/R7/R8";
      default: return "R6/R7/R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [35:0] observed();
    return {flag_n_o, flag_z_o, flag_v_o, flag_c_o, result_o};
  endfunction

  // drive at negedge, sample at the following negedge (one register stage)
  task automatic run_op(input logic [1:0] op, input logic [1:0] wd, input logic two,
                        input logic cin, input logic [31:0] a, input string tag);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; width_i = wd; amount_i = two; carry_i = cin; operand_i = a;
    @(negedge clk_i);
    valid_i = 1'b0;
    checks++;
    if (valid_o !== 1'b1) begin
      errors++;
      $display("FAIL R2 valid: got %b expected 1", valid_o);
    end
    check(tag, observed(), model(op, wd, two, cin, a));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [35:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", {valid_o, observed()} , 37'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle", {3'b0, valid_o}, 36'd0);

    // R3 two-place left shift, byte: second bit out (bit 6) is carry, result zero
    run_op(2'd0, 2'd0, 1'b1, 1'b0, 32'hFFFF_FF40, "R3 shl2 byte");
    run_op(2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_0080, "R3 shl1 byte");
    run_op(2'd0, 2'd1, 1'b1, 1'b1, 32'h0001_6001, "R3 shl2 word");
    run_op(2'd0, 2'd2, 1'b1, 1'b0, 32'hC000_0001, "R3 shl2 long");
    // R4 right shifts, carry from bit 1 on two places
    run_op(2'd1, 2'd0, 1'b1, 1'b0, 32'h0000_0002, "R4 shr2 byte");
    run_op(2'd1, 2'd2, 1'b0, 1'b1, 32'h8000_0000, "R4 shr1 long");
    run_op(2'd1, 2'd1, 1'b1, 1'b0, 32'hABCD_0003, "R4 shr2 word");
    // R5 rotate: amount and carry ignored
    run_op(2'd2, 2'd0, 1'b1, 1'b0, 32'h0000_0001, "R5 rotr byte amt ignored");
    run_op(2'd2, 2'd1, 1'b0, 1'b1, 32'h0000_0002, "R5 rotr word cin ignored");
    run_op(2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_0001, "R5 rotr long");
    // R6 rotate through carry
    run_op(2'd3, 2'd0, 1'b1, 1'b1, 32'h0000_0000, "R6 rotxr byte cin in");
    run_op(2'd3, 2'd1, 1'b0, 1'b0, 32'h0000_0001, "R6 rotxr word zero");
    run_op(2'd3, 2'd2, 1'b0, 1'b1, 32'h0000_0001, "R6 rotxr long");
    // R8 width code 3 behaves as long; high garbage on byte/word
    run_op(2'd1, 2'd3, 1'b0, 1'b0, 32'h8000_0000, "R8 width3 long");
    run_op(2'd0, 2'd0, 1'b0, 1'b0, 32'hFFFF_FF00, "R8 byte high ignored");

    // R2 hold: valid low, change inputs, outputs unchanged
    held = observed();
    @(negedge clk_i);
    operand_i = 32'h1234_5678; op_i = 2'd0; width_i = 2'd2; carry_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R2 hold", {3'b0, valid_o, held}, {4'b0, observed()} | 40'd0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] op, wd;
      op = 2'($urandom);
      wd = 2'($urandom);
      run_op(op, wd, 1'($urandom), 1'($urandom), $urandom, tag_of(op));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule